// File: doc/BRIEF.md
# Instruction Prefetch Queue with Three Stages

This block sits between an instruction memory port and an execution unit. It keeps a short queue of 16-bit instruction words. Each fetched word is latched into stage A and then moved to stage B, where its opcode is offered for decode. When the execution unit signals completion, the word is retired into stage C. Stage C keeps the last completed word until the next instruction finishes. A 20-bit fetch address is formed from a 4-bit extension field above a 16-bit counter. While the queue is full, this address runs three words (six bytes) ahead of the word in stage B.

A change of program flow loads a new target into the fetch address and discards the words held in stages A and B. A memory response that is still outstanding at that moment is tagged stale and dropped when it arrives. The queue then refills from the target. The execution unit can also read an operand word from stage A at full width, or from stage B, where only the low byte is returned.

Top module: `ipf_prefetch`

## Requirements
- R1: After reset, stages A, B and C are empty, the fetch address equals the reset vector, and a memory request is asserted.
- R2: An accepted response word always appears in stage A first. It reaches stage B (dec_valid, dec_word, dec_addr) one or more cycles later. Stage B is never loaded straight from memory.
- R3: When exec_done is high while stage B is valid, stage C holds that word and its address in the next cycle.
- R4: While stage B and stage A are valid and a fetch is outstanding, mem_req_addr equals dec_addr plus 6.
- R5: Each accepted request (mem_req_valid and mem_req_ready both high, no flush) advances the fetch address by 2 bytes. A carry out of the low 16 bits increments the upper 4-bit field. Without an accepted request, the address holds.
- R6: One cycle after flow_load, stages A and B are empty and mem_req_addr equals the flow_target that was sampled.
- R7: After a change of flow, stage B presents the words at target, target+2, target+4 in that order, each word the memory returned for that address.
- R8: opnd_sel = 0 returns the full stage A word. opnd_sel = 1 returns the stage B word with bits 15:8 forced to zero. An empty stage reads as zero.
- R9: flow_load takes priority over advancing A into B in the same cycle. An exec_done in that same cycle still retires the stage B word into stage C.
- R10: A response to a request issued before a flush is accepted and discarded. The first word in stage B after the flush is the one at the target.
- R11: At most one request is outstanding. mem_rsp_ready is low while stage A is full and stage B neither is empty nor is retiring. During that stall, stages A and B hold their contents.
- R12: exec_done while stage B is empty leaves stage C unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 20 | Fetch byte address (extension field over counter) |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Block accepts the response |
| mem_rsp_data | input | 16 | Response instruction word |
| flow_load | input | 1 | Change of program flow |
| flow_target | input | 20 | First-word address of the new stream |
| exec_done | input | 1 | Execution unit finished the stage B instruction |
| dec_valid | output | 1 | Stage B holds a word |
| dec_word | output | 16 | Stage B opcode word |
| dec_addr | output | 20 | Stage B word address |
| ret_valid | output | 1 | Stage C holds a word |
| ret_word | output | 16 | Stage C word |
| ret_addr | output | 20 | Stage C word address |
| a_valid | output | 1 | Stage A holds a word |
| opnd_sel | input | 1 | Operand source: 0 stage A, 1 stage B |
| opnd_word | output | 16 | Operand read result |

## Verification
The bench builds the block with its default widths and a reset vector of 0x0FFF8. This makes the carry from the 16-bit counter into the extension field happen during the first few retirements after reset, with no flush needed. The memory model's latency is varied between one and four cycles, and its request acceptance can be held off. This puts stalled responses, flushes that land on a pending response, and flushes that land on an in-flight request all within reach of directed scenarios.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

   typedef enum logic {
      OPND_FROM_A = 1'b0,
      OPND_FROM_B = 1'b1
   } opnd_src_e;

   // Prefetch lead in bytes: three queued words ahead of the decode stage
   function automatic int lead_bytes(input int bytes_per_word);
      return 3 * bytes_per_word;
   endfunction

endpackage

// File: rtl/ipf_addr_gen.sv
module ipf_addr_gen #(
   parameter int PC_W  = 16,
   parameter int EXT_W = 4,
   parameter int STEP  = 2,
   parameter logic [PC_W+EXT_W-1:0] RESET_VEC = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [PC_W+EXT_W-1:0] load_addr,
   input  logic                  step,
   output logic [PC_W+EXT_W-1:0] addr
);

   localparam int ADDR_W = PC_W + EXT_W;

   generate
      if (EXT_W > 0) begin : g_ext
         logic [PC_W-1:0]  cnt_q;
         logic [EXT_W-1:0] ext_q;
         logic [PC_W:0]    sum;

         assign sum = {1'b0, cnt_q} + (PC_W+1)'(STEP);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= RESET_VEC[PC_W-1:0];
               ext_q <= RESET_VEC[ADDR_W-1:PC_W];
            end else if (load) begin
               cnt_q <= load_addr[PC_W-1:0];
               ext_q <= load_addr[ADDR_W-1:PC_W];
            end else if (step) begin
               cnt_q <= sum[PC_W-1:0];
               ext_q <= ext_q + EXT_W'(sum[PC_W]);
            end
         end

         assign addr = {ext_q, cnt_q};
      end else begin : g_flat
         logic [PC_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= RESET_VEC;
            else if (load)
               cnt_q <= load_addr;
            else if (step)
               cnt_q <= cnt_q + PC_W'(STEP);
         end

         assign addr = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/ipf_fetch_ctl.sv
module ipf_fetch_ctl #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pc,
   input  logic              flush,
   input  logic              slot_free,
   input  logic              req_ready,
   input  logic              rsp_valid,
   output logic              req_valid,
   output logic              rsp_ready,
   output logic              rsp_take,
   output logic              step,
   output logic [ADDR_W-1:0] pend_addr,
   output logic              pend,
   output logic              stale
);

   logic              pend_q, stale_q, pend_nxt;
   logic [ADDR_W-1:0] pend_addr_q;
   logic              req_fire, rsp_fire;

   assign req_valid = !pend_q;
   assign req_fire  = req_valid && req_ready;
   // Stale responses are always taken so they can be discarded
   assign rsp_ready = pend_q && (stale_q || slot_free);
   assign rsp_fire  = rsp_ready && rsp_valid;
   assign rsp_take  = rsp_fire && !stale_q && !flush;
   assign step      = req_fire && !flush;
   assign pend_nxt  = (pend_q && !rsp_fire) || req_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         stale_q     <= 1'b0;
         pend_addr_q <= '0;
      end else begin
         pend_q  <= pend_nxt;
         stale_q <= flush ? pend_nxt : (stale_q && pend_nxt);
         if (req_fire)
            pend_addr_q <= pc;
      end
   end

   assign pend_addr = pend_addr_q;
   assign pend      = pend_q;
   assign stale     = stale_q;

endmodule

// File: rtl/ipf_stage_regs.sv
module ipf_stage_regs #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill,
   input  logic [WORD_W-1:0] fill_word,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              done,
   input  logic              flush,
   output logic              slot_free,
   output logic              a_vld,
   output logic [WORD_W-1:0] a_word,
   output logic [ADDR_W-1:0] a_addr,
   output logic              b_vld,
   output logic [WORD_W-1:0] b_word,
   output logic [ADDR_W-1:0] b_addr,
   output logic              c_vld,
   output logic [WORD_W-1:0] c_word,
   output logic [ADDR_W-1:0] c_addr
);

   logic b_open, advance, retire;

   assign b_open    = !b_vld || done;
   assign advance   = a_vld && b_open && !flush;
   assign retire    = b_vld && done;
   assign slot_free = !a_vld || b_open;

   // Stage A: landing slot for fetched words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_vld  <= 1'b0;
         a_word <= '0;
         a_addr <= '0;
      end else if (flush) begin
         a_vld <= 1'b0;
      end else if (fill) begin
         a_vld  <= 1'b1;
         a_word <= fill_word;
         a_addr <= fill_addr;
      end else if (advance) begin
         a_vld <= 1'b0;
      end
   end

   // Stage B: opcode under decode and execution
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_vld  <= 1'b0;
         b_word <= '0;
         b_addr <= '0;
      end else if (flush) begin
         b_vld <= 1'b0;
      end else if (advance) begin
         b_vld  <= 1'b1;
         b_word <= a_word;
         b_addr <= a_addr;
      end else if (retire) begin
         b_vld <= 1'b0;
      end
   end

   // Stage C: last completed word, kept across flushes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_vld  <= 1'b0;
         c_word <= '0;
         c_addr <= '0;
      end else if (retire) begin
         c_vld  <= 1'b1;
         c_word <= b_word;
         c_addr <= b_addr;
      end
   end

endmodule

// File: rtl/ipf_prefetch.sv
module ipf_prefetch #(
   parameter int WORD_W   = 16,
   parameter int PC_W     = 16,
   parameter int EXT_W    = 4,
   parameter int B_OPND_W = 8,
   parameter logic [PC_W+EXT_W-1:0] RESET_VEC = 20'h00400
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [PC_W+EXT_W-1:0] mem_req_addr,
   input  logic                  mem_rsp_valid,
   output logic                  mem_rsp_ready,
   input  logic [WORD_W-1:0]     mem_rsp_data,
   input  logic                  flow_load,
   input  logic [PC_W+EXT_W-1:0] flow_target,
   input  logic                  exec_done,
   output logic                  dec_valid,
   output logic [WORD_W-1:0]     dec_word,
   output logic [PC_W+EXT_W-1:0] dec_addr,
   output logic                  ret_valid,
   output logic [WORD_W-1:0]     ret_word,
   output logic [PC_W+EXT_W-1:0] ret_addr,
   output logic                  a_valid,
   input  logic                  opnd_sel,
   output logic [WORD_W-1:0]     opnd_word
);

   import ipf_pkg::*;

   localparam int ADDR_W = PC_W + EXT_W;
   localparam int BYTES  = WORD_W / 8;

   generate
      if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
         $error("WORD_W must be a nonzero multiple of 8");
      end
      if (B_OPND_W < 1 || B_OPND_W > WORD_W) begin : g_bad_opnd
         $error("B_OPND_W must lie in 1..WORD_W");
      end
      if (PC_W < 2) begin : g_bad_pc
         $error("PC_W too small");
      end
      if (RESET_VEC % BYTES != 0) begin : g_bad_vec
         $error("RESET_VEC must be word aligned");
      end
   endgenerate

   logic              slot_free, rsp_take, step, pend, stale;
   logic [ADDR_W-1:0] pend_addr, pc;
   logic [WORD_W-1:0] a_word, b_opnd;
   logic [ADDR_W-1:0] a_addr;

   ipf_addr_gen #(
      .PC_W(PC_W), .EXT_W(EXT_W), .STEP(BYTES), .RESET_VEC(RESET_VEC)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .load(flow_load), .load_addr(flow_target),
      .step(step), .addr(pc)
   );

   ipf_fetch_ctl #(.ADDR_W(ADDR_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .pc(pc), .flush(flow_load),
      .slot_free(slot_free), .req_ready(mem_req_ready),
      .rsp_valid(mem_rsp_valid), .req_valid(mem_req_valid),
      .rsp_ready(mem_rsp_ready), .rsp_take(rsp_take), .step(step),
      .pend_addr(pend_addr), .pend(pend), .stale(stale)
   );

   ipf_stage_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_stages (
      .clk(clk), .rst_n(rst_n), .fill(rsp_take), .fill_word(mem_rsp_data),
      .fill_addr(pend_addr), .done(exec_done), .flush(flow_load),
      .slot_free(slot_free),
      .a_vld(a_valid), .a_word(a_word), .a_addr(a_addr),
      .b_vld(dec_valid), .b_word(dec_word), .b_addr(dec_addr),
      .c_vld(ret_valid), .c_word(ret_word), .c_addr(ret_addr)
   );

   assign mem_req_addr = pc;

   generate
      if (B_OPND_W < WORD_W) begin : g_narrow_b
         assign b_opnd = {{(WORD_W-B_OPND_W){1'b0}}, dec_word[B_OPND_W-1:0]};
      end else begin : g_full_b
         assign b_opnd = dec_word;
      end
   endgenerate

   always_comb begin
      if (opnd_src_e'(opnd_sel) == OPND_FROM_B)
         opnd_word = dec_valid ? b_opnd : '0;
      else
         opnd_word = a_valid ? a_word : '0;
   end

endmodule

// File: rtl/ipf_prefetch_chk.sv
module ipf_prefetch_chk #(
   parameter int ADDR_W = 20,
   parameter int WORD_W = 16,
   parameter int BYTES  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_rsp_ready,
   input logic              flow_load,
   input logic [ADDR_W-1:0] flow_target,
   input logic              exec_done,
   input logic              dec_valid,
   input logic [WORD_W-1:0] dec_word,
   input logic [ADDR_W-1:0] dec_addr,
   input logic              ret_valid,
   input logic [WORD_W-1:0] ret_word,
   input logic [ADDR_W-1:0] ret_addr,
   input logic              a_valid,
   input logic [ADDR_W-1:0] a_addr,
   input logic              pend,
   input logic              stale
);

   assert_b_from_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> ($past(a_valid) && dec_addr == $past(a_addr)));

   assert_b_refill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_done && dec_valid && a_valid && !flow_load) |=>
         (dec_valid && dec_addr == $past(a_addr)));

   assert_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_done && dec_valid) |=>
         (ret_valid && ret_word == $past(dec_word) && ret_addr == $past(dec_addr)));

   assert_c_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_done && dec_valid) |=>
         ($stable(ret_valid) && $stable(ret_word) && $stable(ret_addr)));

   assert_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && a_valid && pend && !stale) |->
         (mem_req_addr == dec_addr + ADDR_W'(3 * BYTES)));

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready && !flow_load) |=>
         (mem_req_addr == $past(mem_req_addr) + ADDR_W'(BYTES)));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(mem_req_valid && mem_req_ready) && !flow_load) |=> $stable(mem_req_addr));

   assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flow_load |=> (!dec_valid && !a_valid && mem_req_addr == $past(flow_target)));

   assert_stale_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stale |-> (!a_valid && !dec_valid));

   assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !pend);

   assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && dec_valid && !exec_done && !stale) |-> !mem_rsp_ready);

endmodule

bind ipf_prefetch ipf_prefetch_chk #(
   .ADDR_W(PC_W + EXT_W), .WORD_W(WORD_W), .BYTES(WORD_W / 8)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
   .mem_rsp_ready(mem_rsp_ready), .flow_load(flow_load),
   .flow_target(flow_target), .exec_done(exec_done),
   .dec_valid(dec_valid), .dec_word(dec_word), .dec_addr(dec_addr),
   .ret_valid(ret_valid), .ret_word(ret_word), .ret_addr(ret_addr),
   .a_valid(a_valid), .a_addr(a_addr), .pend(pend), .stale(stale)
);

// File: tb/ipf_prefetch_test.sv
module ipf_prefetch_test;

   localparam logic [19:0] RV = 20'h0FFF8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
   logic [19:0] mem_req_addr, flow_target, dec_addr, ret_addr;
   logic [15:0] mem_rsp_data, dec_word, ret_word, opnd_word;
   logic        flow_load, exec_done, dec_valid, ret_valid, a_valid, opnd_sel;

   int vectors = 0;
   int errors  = 0;
   int lat     = 1;
   bit req_gate = 1'b0;

   ipf_prefetch #(.RESET_VEC(RV)) uut (
      .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
      .mem_rsp_data(mem_rsp_data), .flow_load(flow_load),
      .flow_target(flow_target), .exec_done(exec_done),
      .dec_valid(dec_valid), .dec_word(dec_word), .dec_addr(dec_addr),
      .ret_valid(ret_valid), .ret_word(ret_word), .ret_addr(ret_addr),
      .a_valid(a_valid), .opnd_sel(opnd_sel), .opnd_word(opnd_word)
   );

   always #5 clk = ~clk;

   function automatic logic [15:0] memw(input logic [19:0] a);
      return a[16:1] ^ 16'h3C5A;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Memory model: samples handshakes before each edge, updates after it
   initial begin
      bit rf, pf, pend;
      logic [19:0] af, paddr;
      int cnt;
      pend = 0; cnt = 0; paddr = '0;
      mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      forever begin
         @(negedge clk); #2;
         rf = mem_req_valid && mem_req_ready;
         af = mem_req_addr;
         pf = mem_rsp_valid && mem_rsp_ready;
         @(posedge clk); #1;
         if (!rst_n) begin
            pend = 0; mem_rsp_valid = 1'b0;
         end else begin
            if (pf) begin mem_rsp_valid = 1'b0; pend = 0; end
            if (rf) begin pend = 1; paddr = af; cnt = lat; end
            if (pend && !mem_rsp_valid) begin
               cnt--;
               if (cnt <= 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = memw(paddr); end
            end
         end
         mem_req_ready = !req_gate;
      end
   end

   task automatic step_n(input int n);
      repeat (n) @(negedge clk);
      #3;
   endtask

   // Wait for a decoded word, complete it, and check stage C
   task automatic retire_one(input string req, input logic [19:0] exp_addr);
      int guard = 0;
      @(negedge clk);
      while (!dec_valid && guard < 60) begin @(negedge clk); guard++; end
      check({req, " decode addr"}, {12'd0, dec_addr}, {12'd0, exp_addr});
      check({req, " decode word"}, {16'd0, dec_word}, {16'd0, memw(exp_addr)});
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
      #3;
      check("R3 retire valid", {31'd0, ret_valid}, 32'd1);
      check("R3 retire addr", {12'd0, ret_addr}, {12'd0, exp_addr});
      check("R3 retire word", {16'd0, ret_word}, {16'd0, memw(exp_addr)});
   endtask

   task automatic t_reset;
      #3;
      check("R1 a empty", {31'd0, a_valid}, 32'd0);
      check("R1 b empty", {31'd0, dec_valid}, 32'd0);
      check("R1 c empty", {31'd0, ret_valid}, 32'd0);
      check("R1 vector", {12'd0, mem_req_addr}, {12'd0, RV});
      check("R1 request", {31'd0, mem_req_valid}, 32'd1);
   endtask

   task automatic t_fill;
      int guard = 0;
      while (!a_valid && guard < 20) begin step_n(1); guard++; end
      check("R2 first word in A", {31'd0, a_valid}, 32'd1);
      check("R2 B still empty", {31'd0, dec_valid}, 32'd0);
      step_n(1);
      check("R2 B loaded", {31'd0, dec_valid}, 32'd1);
      check("R2 B addr", {12'd0, dec_addr}, {12'd0, RV});
      step_n(8);
      check("R4 lead of six", {12'd0, mem_req_addr}, {12'd0, RV + 20'd6});
      check("R11 stall ready low", {31'd0, mem_rsp_ready}, 32'd0);
      check("R11 B held", {12'd0, dec_addr}, {12'd0, RV});
      opnd_sel = 1'b0; #1;
      check("R8 operand A", {16'd0, opnd_word}, {16'd0, memw(RV + 20'd2)});
      opnd_sel = 1'b1; #1;
      check("R8 operand B low byte", {16'd0, opnd_word}, {24'd0, memw(RV)[7:0]});
      opnd_sel = 1'b0;
   endtask

   task automatic t_stream;
      retire_one("R3 seq0", RV);
      step_n(4);
      check("R5 carry into ext", {12'd0, mem_req_addr}, 32'h0001_0000);
      check("R4 lead after retire", {12'd0, mem_req_addr}, {12'd0, dec_addr + 20'd6});
      retire_one("R3 seq1", RV + 20'd2);
      retire_one("R3 seq2", RV + 20'd4);
      retire_one("R3 seq3", RV + 20'd6);
      step_n(4);
      check("R4 lead across carry", {12'd0, mem_req_addr}, {12'd0, dec_addr + 20'd6});
   endtask

   task automatic t_flush;
      logic [19:0] br_addr;
      logic [15:0] br_word;
      lat = 4;
      @(negedge clk);
      br_addr = dec_addr; br_word = dec_word;
      flow_load = 1'b1; flow_target = 20'h34560; exec_done = 1'b1;
      @(negedge clk);
      flow_load = 1'b0; exec_done = 1'b0;
      #3;
      check("R9 branch retired", {12'd0, ret_addr}, {12'd0, br_addr});
      check("R9 branch word", {16'd0, ret_word}, {16'd0, br_word});
      check("R6 A flushed", {31'd0, a_valid}, 32'd0);
      check("R6 B flushed", {31'd0, dec_valid}, 32'd0);
      check("R6 target loaded", {12'd0, mem_req_addr}, 32'h0003_4560);
      @(negedge clk);
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
      #3;
      check("R12 C kept addr", {12'd0, ret_addr}, {12'd0, br_addr});
      check("R12 C kept word", {16'd0, ret_word}, {16'd0, br_word});
      retire_one("R7 target", 20'h34560);
      retire_one("R7 target+2", 20'h34562);
      retire_one("R7 target+4", 20'h34564);
   endtask

   task automatic t_stale;
      @(negedge clk);
      flow_load = 1'b1; flow_target = 20'h50000;
      @(negedge clk);
      flow_load = 1'b0;
      #3;
      check("R6 first target", {12'd0, mem_req_addr}, 32'h0005_0000);
      @(negedge clk);
      flow_load = 1'b1; flow_target = 20'hA1230;
      @(negedge clk);
      flow_load = 1'b0;
      #3;
      check("R11 no second request", {31'd0, mem_req_valid}, 32'd0);
      check("R10 B empty", {31'd0, dec_valid}, 32'd0);
      retire_one("R10 new stream", 20'hA1230);
      retire_one("R10 next", 20'hA1232);
   endtask

   task automatic t_gate;
      lat = 1;
      req_gate = 1'b1;
      @(negedge clk);
      flow_load = 1'b1; flow_target = 20'h07FFE;
      @(negedge clk);
      flow_load = 1'b0;
      step_n(6);
      check("R5 addr holds without accept", {12'd0, mem_req_addr}, 32'h0000_7FFE);
      check("R5 nothing fetched", {31'd0, a_valid}, 32'd0);
      req_gate = 1'b0;
      retire_one("R7 gated target", 20'h07FFE);
      retire_one("R5 no ext carry", 20'h08000);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; flow_load = 1'b0; flow_target = '0;
      exec_done = 1'b0; opnd_sel = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_stream();
      t_flush();
      t_stale();
      t_gate();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule